// File: doc/BRIEF.md
# 48-Bit Always-On Tick Counter with Snapshot and Byte Setting

This block keeps a 48-bit count of slow timebase ticks. A single-cycle `tick` pulse, already synchronous to `clk`, moves the count forward by one. The count register sits in its own always-on reset domain (`aon_rst_n`). Asserting the system reset (`rst_n`) therefore never disturbs it. Only the bus-side logic returns to its reset state.

Software reads the count through a small byte-wide register window. A write to address 0 copies the whole live count into six holding bytes, and software reads those bytes at its leisure. The snapshot is taken without any handshake with the tick, so two snapshots taken close together may differ by one.

The control register at address 6 accepts a two-write command sequence. The sequence either zeroes the count, or zeroes it and enters a byte-setting mode. In that mode each later control write bumps the bytes it selects, so software can dial in any starting value.

Top module: `rtc_counter48`

## Requirements
- R1: Each cycle with `tick` high adds one to the 48-bit count, and the count wraps from all ones to zero. The count holds whenever there is no tick, no zeroing command and no byte bump.
- R2: A low `rst_n` leaves the count untouched and keeps it counting ticks. It clears the holding bytes to zero and returns the command sequencer to idle, which also leaves byte-setting mode.
- R3: A write of any value to address 0 copies into the holding bytes the count as it stood before that write's clock edge. Reads of address n (0 to 5) return holding byte n, where byte 0 holds bits 7:0, and never return the live count. Reads of addresses 6 and 7 return zero.
- R4: Writing 0x40 and then 0x80 to address 6 zeroes the count. A repeated 0x40 while armed keeps the sequence armed.
- R5: Writing 0x40 and then 0xC0 to address 6 zeroes the count and enters byte-setting mode.
- R6: In byte-setting mode, a write to address 6 with bit n set (n from 0 to 5) adds one, modulo 256, to byte n only, with no carry into byte n+1. Bits 7:6 of the write are ignored.
- R7: While byte-setting mode is active, ticks do not change the count.
- R8: Writing 0x00 to address 6 in byte-setting mode leaves the mode, and ticks count again from the current value.
- R9: While armed, any control write other than 0x40, 0x80 or 0xC0 cancels the sequence. For example, 0x40, 0x00, 0x80 leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | System reset, active low, synchronous |
| aon_rst_n | input | 1 | Always-on domain reset for the count, active low, synchronous |
| tick | input | 1 | One-cycle timebase pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address: 0 to 5 are snapshot bytes (a write to 0 latches), 6 is control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |

## Verification
Plain tick bursts of different lengths, including one that crosses a byte boundary, separate a correct increment from a stuck or truncated counter. Command sequences are tried in their valid forms, with a re-armed prefix, and with an interrupting write. These patterns tell zeroing apart from a sequence that was wrongly cancelled or wrongly accepted. Byte-setting writes select single bytes, several bytes and all bytes, and are repeated until a byte passes 0xFF. This distinguishes per-byte increments from carrying ones, and shows that ticks are ignored meanwhile. A system reset pulsed with ticks still arriving shows that the count survives while the holding bytes and the mode are cleared.

// File: rtl/rtc48_pkg.sv
// Shared encodings for the 48-bit always-on tick counter.
package rtc48_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_BUMP  = 2'd2
    } seq_e;

    localparam logic [7:0] CMD_ARM       = 8'h40;
    localparam logic [7:0] CMD_ZERO      = 8'h80;
    localparam logic [7:0] CMD_ZERO_BUMP = 8'hC0;
    localparam logic [7:0] CMD_EXIT      = 8'h00;
endpackage

// File: rtl/rtc48_seq.sv
// Control-write sequencer. It decodes the arm/zero command pair and the
// byte-setting mode, and produces a one-cycle clear and a per-byte bump mask.
// Assumes BYTES <= 6 so that the bump mask never reaches the command bits 7:6.
module rtc48_seq
    import rtc48_pkg::*;
#(
    parameter int BYTES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_data,
    output logic             clr,
    output logic [BYTES-1:0] bump,
    output logic             incr_mode
);
    seq_e state_q, state_d;

    // Next state and command outputs for the current control write.
    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        bump    = '0;
        if (ctl_we) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (ctl_data == CMD_ARM) state_d = SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    if (ctl_data == CMD_ZERO) begin
                        clr     = 1'b1;
                        state_d = SEQ_IDLE;
                    end else if (ctl_data == CMD_ZERO_BUMP) begin
                        clr     = 1'b1;
                        state_d = SEQ_BUMP;
                    end else if (ctl_data == CMD_ARM) begin
                        state_d = SEQ_ARMED;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
                SEQ_BUMP: begin
                    if (ctl_data == CMD_EXIT) state_d = SEQ_IDLE;
                    else                      bump    = ctl_data[BYTES-1:0];
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // Sequencer state register, system reset domain.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign incr_mode = (state_q == SEQ_BUMP);
endmodule

// File: rtl/rtc48_count.sv
// Always-on counter. It advances by one per tick, zeroes on clr, and in
// byte-setting mode bumps the selected bytes with no inter-byte carry.
// Assumes clr and bump come from the same clock as tick.
module rtc48_count #(
    parameter int BYTES = 6,
    parameter int BW    = 8
) (
    input  logic                clk,
    input  logic                aon_rst_n,
    input  logic                tick,
    input  logic                clr,
    input  logic                incr_mode,
    input  logic [BYTES-1:0]    bump,
    output logic [BYTES*BW-1:0] cnt
);
    localparam int CNT_W = BYTES * BW;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bumped;

    // Per-byte increment with no carry between bytes.
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign bumped[g*BW +: BW] = bump[g] ? cnt_q[g*BW +: BW] + BW'(1)
                                            : cnt_q[g*BW +: BW];
    end

    // Count register: clear, then byte setting, then normal ticks.
    always_ff @(posedge clk) begin
        if (!aon_rst_n)     cnt_q <= '0;
        else if (clr)       cnt_q <= '0;
        else if (incr_mode) cnt_q <= bumped;
        else if (tick)      cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rtc48_snap.sv
// Snapshot holding bytes and the read multiplexer. A latch strobe copies the
// live count into the holding bytes. Reads see the holding bytes only, and
// any address past the last byte reads zero.
module rtc48_snap #(
    parameter int BYTES  = 6,
    parameter int BW     = 8,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                snap_we,
    input  logic [BYTES*BW-1:0] live,
    input  logic [ADDR_W-1:0]   addr,
    output logic [BYTES*BW-1:0] hold,
    output logic [BW-1:0]       rdata
);
    logic [BYTES*BW-1:0] hold_q;

    // Holding bytes, system reset domain.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (snap_we) hold_q <= live;
    end

    // Byte select for reads.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (addr == ADDR_W'(i)) rdata = hold_q[i*BW +: BW];
        end
    end

    assign hold = hold_q;
endmodule

// File: rtl/rtc_counter48.sv
// Top of the always-on tick counter. It decodes the register window
// (bytes 0..BYTES-1, control at BYTES) and ties together the sequencer,
// the counter and the snapshot. The count is reset only by aon_rst_n.
module rtc_counter48 #(
    parameter int BYTES  = 6,
    parameter int BW     = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aon_rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BW-1:0]     wdata,
    output logic [BW-1:0]     rdata
);
    localparam int CNT_W = BYTES * BW;
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(BYTES);

    logic             snap_we, ctl_we, clr, incr_mode;
    logic [BYTES-1:0] bump;
    logic [CNT_W-1:0] cnt_q, hold_q;

    // Address decode, with writes masked during system reset.
    assign snap_we = wr_en && rst_n && (addr == '0);
    assign ctl_we  = wr_en && rst_n && (addr == CTL_ADDR);

    rtc48_seq #(.BYTES(BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_data  (wdata[7:0]),
        .clr       (clr),
        .bump      (bump),
        .incr_mode (incr_mode)
    );

    rtc48_count #(.BYTES(BYTES), .BW(BW)) u_count (
        .clk       (clk),
        .aon_rst_n (aon_rst_n),
        .tick      (tick),
        .clr       (clr),
        .incr_mode (incr_mode),
        .bump      (bump),
        .cnt       (cnt_q)
    );

    rtc48_snap #(.BYTES(BYTES), .BW(BW), .ADDR_W(ADDR_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap_we (snap_we),
        .live    (cnt_q),
        .addr    (addr),
        .hold    (hold_q),
        .rdata   (rdata)
    );
endmodule

// File: rtl/rtc_counter48_chk.sv
// Property checker for rtc_counter48, attached by bind. It observes the
// count, the holding bytes and the sequencer outputs across reset domains.
module rtc_counter48_chk #(
    parameter int BYTES = 6,
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             aon_rst_n,
    input logic             tick,
    input logic             snap_we,
    input logic             clr,
    input logic             incr_mode,
    input logic [BYTES-1:0] bump,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] hold_q
);
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (tick && !clr && !incr_mode) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (!tick && !clr && bump == '0) |=> $stable(cnt_q)); // R1
    AST_SYSRST_KEEP: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (!rst_n && !tick) |=> $stable(cnt_q)); // R2
    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
        snap_we |=> hold_q == $past(cnt_q)); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!aon_rst_n)
        clr |=> cnt_q == '0); // R4
    AST_BUMP_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bump != '0) |-> incr_mode); // R6
    AST_MODE_NO_TICK: assert property (@(posedge clk) disable iff (!aon_rst_n || !rst_n)
        (incr_mode && !clr && bump == '0) |=> $stable(cnt_q)); // R7
endmodule

bind rtc_counter48 rtc_counter48_chk #(.BYTES(BYTES), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .aon_rst_n (aon_rst_n),
    .tick      (tick),
    .snap_we   (snap_we),
    .clr       (clr),
    .incr_mode (incr_mode),
    .bump      (bump),
    .cnt_q     (cnt_q),
    .hold_q    (hold_q)
);

// File: tb/rtc_counter48_tb.sv
`timescale 1ns/1ps
module rtc_counter48_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aon_rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rtc_counter48 u_dut (
        .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .tick(tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Vector: {req[3:0], op[1:0], arg[7:0], exp[47:0]}; op 0 tick burst, 1 control write, 2 check.
    localparam int NV = 29;
    localparam logic [61:0] VEC [NV] = '{
        {4'd1, 2'd2, 8'h00, 48'h0},               // R1 reset state
        {4'd1, 2'd0, 8'd5,  48'h0},
        {4'd1, 2'd2, 8'h00, 48'h5},               // R1
        {4'd1, 2'd0, 8'd255, 48'h0},
        {4'd1, 2'd2, 8'h00, 48'h104},             // R1 crosses byte 0
        {4'd4, 2'd1, 8'h40, 48'h0},
        {4'd4, 2'd1, 8'h80, 48'h0},
        {4'd4, 2'd2, 8'h00, 48'h0},               // R4
        {4'd9, 2'd0, 8'd3,  48'h0},
        {4'd9, 2'd1, 8'h40, 48'h0},
        {4'd9, 2'd1, 8'h00, 48'h0},
        {4'd9, 2'd1, 8'h80, 48'h0},
        {4'd9, 2'd2, 8'h00, 48'h3},               // R9 cancelled
        {4'd4, 2'd1, 8'h40, 48'h0},
        {4'd4, 2'd1, 8'h40, 48'h0},
        {4'd4, 2'd1, 8'h80, 48'h0},
        {4'd4, 2'd2, 8'h00, 48'h0},               // R4 re-armed
        {4'd5, 2'd0, 8'd2,  48'h0},
        {4'd5, 2'd1, 8'h40, 48'h0},
        {4'd5, 2'd1, 8'hC0, 48'h0},
        {4'd6, 2'd1, 8'h01, 48'h0},
        {4'd6, 2'd1, 8'hE1, 48'h0},               // R6 bits 7:6 ignored
        {4'd7, 2'd0, 8'd10, 48'h0},
        {4'd7, 2'd2, 8'h00, 48'h010000000002},    // R5 R6 R7
        {4'd6, 2'd1, 8'h3F, 48'h0},
        {4'd6, 2'd2, 8'h00, 48'h020101010103},    // R6
        {4'd8, 2'd1, 8'h00, 48'h0},
        {4'd8, 2'd0, 8'd1,  48'h0},
        {4'd8, 2'd2, 8'h00, 48'h020101010104}     // R8
    };

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic read_hold(output logic [47:0] v);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); addr = 3'(i);
            #1 v[i*8 +: 8] = rdata;
        end
    endtask

    task automatic check48(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic latch_and_check(input string req, input logic [47:0] exp);
        logic [47:0] v;
        bus_write(3'd0, 8'h5A);
        read_hold(v);
        check48(req, v, exp);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; aon_rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NV; n++) begin
            logic [61:0] e;
            e = VEC[n];
            case (e[57:56])
                2'd0: pulse_ticks(int'(e[55:48]));
                2'd1: bus_write(3'd6, e[55:48]);
                default: latch_and_check($sformatf("R%0d vec%0d", e[61:58], n), e[47:0]);
            endcase
        end

        // R3: holding bytes are not live; address 6 reads zero.
        bus_write(3'd0, 8'h00);
        pulse_ticks(1);
        read_hold(v);
        check48("R3 stale", v, 48'h020101010104);
        @(negedge clk); addr = 3'd6;
        #1 check48("R3 ctl read", {40'h0, rdata}, 48'h0);
        latch_and_check("R3 fresh", 48'h020101010105);

        // R2: system reset with ticks still arriving.
        @(negedge clk); rst_n = 1'b0;
        pulse_ticks(2);
        @(negedge clk); rst_n = 1'b1;
        read_hold(v);
        check48("R2 hold cleared", v, 48'h0);
        latch_and_check("R2 count kept", 48'h020101010107);

        // R2: system reset leaves byte-setting mode.
        bus_write(3'd6, 8'h40);
        bus_write(3'd6, 8'hC0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        pulse_ticks(1);
        latch_and_check("R2 mode exit", 48'h1);

        // R6 and R1: every byte to 0xFF, no carry, then wrap.
        bus_write(3'd6, 8'h40);
        bus_write(3'd6, 8'hC0);
        for (int k = 0; k < 255; k++) bus_write(3'd6, 8'h3F);
        latch_and_check("R6 all ones", 48'hFFFFFFFFFFFF);
        bus_write(3'd6, 8'h01);
        latch_and_check("R6 no carry", 48'hFFFFFFFFFF00);
        for (int k = 0; k < 255; k++) bus_write(3'd6, 8'h01);
        bus_write(3'd6, 8'h00);
        latch_and_check("R8 exit value", 48'hFFFFFFFFFFFF);
        pulse_ticks(1);
        latch_and_check("R1 wrap", 48'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule